// File: doc/BRIEF.md
# Programmable Half-Step Clock Divider

This block derives a slower clock from a fast input clock. A 3-bit select input picks one of seven ratios: 1 (the input clock passes straight through), 1.5, 2, 3, 4, 6 and 8. Two codes both give divide-by-3. The output clock is the time base for synchronous transfer control logic. A companion strobe, one input cycle wide and in the fast clock domain, marks every cycle in which the divided clock rises. Logic that stays on the fast clock uses that strobe as a clock enable.

The divider counts in half-periods of the input clock. This lets the 1.5 ratio and an exactly symmetric divide-by-3 come out of the same counter as the even ratios. On each rising edge of the input clock, two registered levels are formed: one for the high phase of that input cycle and one for the low phase. The input clock selects between them. The select input may change at any time. The active ratio is replaced only when an output period ends on a rising edge of the input clock, so no shortened pulse appears.

The select input and the output are plain control signals. There is no data stream, so no handshake is involved.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_ni` is low, `clk_o` and `tick_o` are both held low.
- R2: The select code sets the output period as a count of input half-periods: 000→6, 001→2, 010→3, 011→4, 100→6, 101→8, 110→12, 111→16. An output period starts with its high part, which lasts ceil(P/2) half-periods, and continues low for the rest.
- R3: With code 001, `clk_o` follows the input clock and `tick_o` is high in every input cycle.
- R4: With code 010, the output repeats high, high, low over three input half-periods, which gives two output periods in every three input cycles.
- R5: With codes 011, 101, 110 and 111, the output has an exact 50% duty cycle.
- R6: With codes 000 and 100, the output is high for three input half-periods and low for three, so divide-by-3 is symmetric.
- R7: `tick_o` is high for exactly those input cycles (rising edge to rising edge) during which `clk_o` rises, whether the rise falls at the start of the cycle or in its middle.
- R8: A new select code takes effect only at the first input rising edge at which the current output period ends. The code sampled on that edge then starts a fresh period, and the running period is never cut short.
- R9: After reset is released, the first input rising edge starts an output period, so `clk_o` goes high on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Divide ratio select code |
| clk_o | output | 1 | Divided clock |
| tick_o | output | 1 | One-cycle strobe in the `clk_i` domain, high in each cycle where `clk_o` rises |

## Verification
For every code, the bench compares `clk_o` in both halves of every input cycle against a half-period index model. This catches a divider that rounds 1.5 to 1 or 2, or one that makes divide-by-3 lopsided. It also changes the code for every ordered pair of codes, at several offsets into a period. A design that switched at once would leave a runt or an over-long pulse. So would one that waited for the boundary but restarted the count at the wrong index. For 1.5 the period ends in mid-cycle, so the bench checks that the switch waits for an edge-aligned boundary. The strobe is checked on cycles where the rise falls on the falling edge, because a design that only watched the start of each cycle would drop those strobes.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int SEL_W = 3;
  localparam int PH_W  = 5;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [PH_W-1:0]  ph_t;

  typedef struct packed {
    ph_t period;  // output period in input half-periods
    ph_t high;    // half-periods of high level at the start of a period
  } ratio_t;

  function automatic ratio_t code_to_ratio(sel_t code);
    ratio_t r;
    case (code)
      3'b001:  r.period = PH_W'(2);
      3'b010:  r.period = PH_W'(3);
      3'b011:  r.period = PH_W'(4);
      3'b101:  r.period = PH_W'(8);
      3'b110:  r.period = PH_W'(12);
      3'b111:  r.period = PH_W'(16);
      default: r.period = PH_W'(6);
    endcase
    r.high = (r.period + PH_W'(1)) >> 1;
    return r;
  endfunction
endpackage

// File: rtl/fdiv_decode.sv
module fdiv_decode
  import frac_div_pkg::*;
(
  input  sel_t   code_i,
  output ratio_t ratio_o
);
  always_comb ratio_o = code_to_ratio(code_i);
endmodule

// File: rtl/fdiv_phase.sv
module fdiv_phase
  import frac_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sel_t   sel_i,
  output ratio_t ratio_o,  // ratio governing the current input cycle
  output ph_t    first_o,  // half index covered by the high phase of clk_i
  output ph_t    second_o  // half index covered by the low phase of clk_i
);
  sel_t   active_q;
  ph_t    ph_q;
  ratio_t req_r, act_r, eff_r;
  logic   edge_bound;
  ph_t    sum1, sum2, ph_d;

  fdiv_decode u_dec_req (.code_i(sel_i),    .ratio_o(req_r));
  fdiv_decode u_dec_act (.code_i(active_q), .ratio_o(act_r));

  // A period boundary on a rising edge is the only point where the ratio may change
  always_comb begin
    edge_bound = (ph_q == '0);
    eff_r      = edge_bound ? req_r : act_r;
    sum1       = ph_q + PH_W'(1);
    sum2       = ph_q + PH_W'(2);
    second_o   = (sum1 == eff_r.period) ? '0 : sum1;
    ph_d       = (sum2 >= eff_r.period) ? (sum2 - eff_r.period) : sum2;
    first_o    = ph_q;
    ratio_o    = eff_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      ph_q     <= '0;
    end else begin
      if (edge_bound) active_q <= sel_i;
      ph_q <= ph_d;
    end
  end
endmodule

// File: rtl/fdiv_level.sv
module fdiv_level
  import frac_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t ratio_i,
  input  ph_t    first_i,
  input  ph_t    second_i,
  output logic   hi_q_o,
  output logic   lo_q_o,
  output logic   tick_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q_o   <= 1'b0;
      lo_q_o   <= 1'b0;
      tick_q_o <= 1'b0;
    end else begin
      hi_q_o   <= (first_i  < ratio_i.high);
      lo_q_o   <= (second_i < ratio_i.high);
      tick_q_o <= (first_i == '0) || (second_i == '0);
    end
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o,
  output logic             tick_o
);
  ratio_t ratio;
  ph_t    first_idx, second_idx;
  logic   hi_q, lo_q, tick_q;

  fdiv_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .ratio_o  (ratio),
    .first_o  (first_idx),
    .second_o (second_idx)
  );

  fdiv_level u_level (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ratio_i  (ratio),
    .first_i  (first_idx),
    .second_i (second_idx),
    .hi_q_o   (hi_q),
    .lo_q_o   (lo_q),
    .tick_q_o (tick_q)
  );

  // Each input phase shows the level registered for it
  always_comb begin
    clk_o  = clk_i ? hi_q : lo_q;
    tick_o = tick_q;
  end
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk
  import frac_div_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input ratio_t ratio,
  input ph_t    first_idx,
  input logic   hi_q,
  input logic   lo_q,
  input logic   tick_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!hi_q && !lo_q && !tick_o)); // R1

  AST_INDEX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_idx < ratio.period); // R2

  AST_BYPASS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio.period == PH_W'(2)) |=> (hi_q && !lo_q && tick_o)); // R3

  AST_ONE_HALF_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio.period == PH_W'(3)) |=> (hi_q || lo_q)); // R4

  AST_EVEN_SYMMETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio.period[1:0] == 2'b00) |=> (hi_q == lo_q)); // R5

  AST_TICK_WITH_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (hi_q || lo_q)); // R7

  AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_idx != '0) |-> $stable(ratio)); // R8
endmodule

bind frac_clk_div frac_clk_div_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ratio     (ratio),
  .first_idx (first_idx),
  .hi_q      (hi_q),
  .lo_q      (lo_q),
  .tick_o    (tick_o)
);

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
  localparam int T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       clk_o, tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int cyc, seg, p_cur, act_code, rises, prev_lvl;
  bit switched;

  frac_clk_div u_frac_clk_div (
    .clk_i (clk), .rst_ni (rst_n), .sel_i (sel), .clk_o (clk_o), .tick_o (tick_o)
  );

  always #(T/2) clk = ~clk;

  function automatic int period_of(int code);
    case (code)
      1: return 2;  2: return 3;  3: return 4;  5: return 8;
      6: return 12; 7: return 16; default: return 6;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic string lvl_tag();
    if (cyc == 0) return "R9";
    if (switched) return "R8";
    case (act_code)
      1: return "R3";
      2: return "R4";
      0, 4: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic do_reset(int code);
    rst_n = 1'b0;
    sel   = 3'(code);
    repeat (2) @(posedge clk);
    #(T/4);
    chk(clk_o == 1'b0, "R1 clk_o high phase", int'(clk_o), 0);
    chk(tick_o == 1'b0, "R1 tick_o", int'(tick_o), 0);
    #(T/2);
    chk(clk_o == 1'b0, "R1 clk_o low phase", int'(clk_o), 0);
    rst_n = 1'b1;
    cyc = 0; seg = 0; p_cur = 1; act_code = code;
    switched = 0; rises = 0; prev_lvl = 0;
  endtask

  task automatic step();
    int h, m0, m1, hi;
    bit e0, e1, et;
    h = 2 * cyc;
    if (((h - seg) % p_cur) == 0) begin
      if (cyc != 0 && int'(sel) != act_code) switched = 1;
      seg = h; p_cur = period_of(int'(sel)); act_code = int'(sel);
    end
    hi = (p_cur + 1) / 2;
    m0 = (h - seg) % p_cur;
    m1 = (h + 1 - seg) % p_cur;
    e0 = (m0 < hi); e1 = (m1 < hi);
    et = (m0 == 0) || (m1 == 0);
    @(posedge clk);
    #(T/4);
    chk(clk_o == e0, lvl_tag(), int'(clk_o), int'(e0));
    chk(tick_o == et, "R7 tick", int'(tick_o), int'(et));
    if (clk_o && !prev_lvl) rises++;
    prev_lvl = int'(clk_o);
    #(T/2);
    chk(clk_o == e1, lvl_tag(), int'(clk_o), int'(e1));
    if (clk_o && !prev_lvl) rises++;
    prev_lvl = int'(clk_o);
    cyc++;
  endtask

  initial begin
    #(T * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int offs[4] = '{1, 2, 3, 5};
    // Steady sweep of every code
    for (int code = 0; code < 8; code++) begin
      do_reset(code);
      repeat (48) step();
      chk(rises == 95 / period_of(code) + 1, "R2 rising edges in 96 halves",
          rises, 95 / period_of(code) + 1);
    end
    // Every ordered pair of codes, switched at several offsets
    for (int o = 0; o < 8; o++)
      for (int n = 0; n < 8; n++)
        for (int k = 0; k < 4; k++) begin
          do_reset(o);
          repeat (offs[k]) step();
          sel = 3'(n);
          repeat (24) step();
        end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule